// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A controller for thirteen general-purpose pins, reached over a byte-wide register bus with an address, write data, a write strobe, a read strobe and registered read data. Each pin owns two registers. The first sets direction, drive type, pull selection and output level. The second reports the synchronized pad level and selects which edge raises an interrupt. The drive and pull settings leave the block only as control signals for the pad cells.

Each pad input passes through two synchronizer flops before edge detection. A qualified edge sets a sticky status bit. Status bits are packed into two group registers: pins 0–6 in the first, pins 7–12 in the second. Each group has a matching mask register. Software clears status by writing ones. One interrupt line is the OR of every status bit whose mask bit is clear.

Address map (ADDR_W = 6):
- 0x00–0x0C: output control, pin 0 to pin 12.
- 0x0D–0x19: input control, pin 0 to pin 12.
- 0x20 and 0x21: status for group 0 and group 1.
- 0x28 and 0x29: mask for group 0 and group 1.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: The output-control register of each pin holds six bits, and reads back exactly what was written in bits 5:0. Bit 5 is direction (1 = output), bit 4 is drive (1 = push-pull, 0 = open-drain), bit 3 is pull enable, bits 2:1 are pull select and bit 0 is output level.
- R2: pad_out_o carries the level bit, pull_en_o carries the pull-enable bit, and pull_sel_o[2p+1:2p] carries the pull select of pin p.
- R3: pad_oe_o is 0 when direction is input. It is 1 for a push-pull output. For an open-drain output it is 1 only while the level bit is 0.
- R4: Input-control bit 0 reads the pad level after a two-flop synchronizer. Bits 2:1 read back the edge select last written.
- R5: Edge select 00 detects nothing, 01 detects falling edges, 10 detects rising edges and 11 detects both. A detected edge sets the pin's status bit, which is readable on the second read after the pad change settles.
- R6: Status and mask for pins 0–6 sit at bits 6:0 of the group-0 register. Pins 7–12 sit at bits 5:0 of the group-1 register, at bit position pin−7.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Status bits are sticky until cleared.
- R8: An edge detected in the same cycle as a clearing write to that bit leaves the bit set.
- R9: irq_o is high when any status bit has its mask bit clear. A set mask bit keeps that pin from the interrupt line without clearing its status. Mask bits read back as written.
- R10: After reset all registers read 0, so every mask bit is clear, and irq_o is low.
- R11: Unused upper bits of every register, and unmapped addresses, read 0 and ignore writes.
- R12: rd_data_o updates at the clock edge where rd_en_i is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| pad_in_i | input | 13 | Pad input levels |
| pad_out_o | output | 13 | Output level per pin |
| pad_oe_o | output | 13 | Output driver enable per pin |
| pull_en_o | output | 13 | Pull resistor enable per pin |
| pull_sel_o | output | 26 | Pull selection, two bits per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench places an edge in the same clock as a write-one-to-clear of that bit. A design that gives the clear priority would read 0 there and lose the event. It drives every edge-select code with both edge directions on pins at the group-0 top, the group-1 bottom and the last pin. An off-by-one in the uneven group packing, or swapped rise and fall codes, therefore lands in the wrong bit or stays silent. It walks the open-drain output through both levels, because an enable that ignores the level would drive a high onto a shared line. It writes all ones into group, control and unmapped registers to catch state that is not cut to its defined width.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int OC_DIR  = 5;
  localparam int OC_DRV  = 4;
  localparam int OC_PEN  = 3;
  localparam int OC_LVL  = 0;
  localparam int OC_BITS = 6;
endpackage

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_edge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pad_in_i,
  input  logic               oc_we_i,
  input  logic [OC_BITS-1:0] oc_wdata_i,
  input  logic               ic_we_i,
  input  logic [1:0]         ic_wdata_i,
  output logic [OC_BITS-1:0] oc_q_o,
  output logic [2:0]         ic_rd_o,
  output logic               event_o,
  output logic               pad_out_o,
  output logic               pad_oe_o,
  output logic               pull_en_o,
  output logic [1:0]         pull_sel_o
);
  logic [OC_BITS-1:0] oc_q;
  edge_sel_e          edge_q;
  logic               sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q    <= '0;
      edge_q  <= EDGE_OFF;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      if (oc_we_i) oc_q <= oc_wdata_i;
      if (ic_we_i) edge_q <= edge_sel_e'(ic_wdata_i);
      sync1_q <= pad_in_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    unique case (edge_q)
      EDGE_RISE: event_o = sync2_q & ~prev_q;
      EDGE_FALL: event_o = ~sync2_q & prev_q;
      EDGE_BOTH: event_o = sync2_q ^ prev_q;
      default:   event_o = 1'b0;
    endcase
  end

  assign oc_q_o     = oc_q;
  assign ic_rd_o    = {edge_q, sync2_q};
  assign pad_out_o  = oc_q[OC_LVL];
  // open-drain only pulls low
  assign pad_oe_o   = oc_q[OC_DIR] & (oc_q[OC_DRV] | ~oc_q[OC_LVL]);
  assign pull_en_o  = oc_q[OC_PEN];
  assign pull_sel_o = oc_q[2:1];

  assert_input_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oc_q_o[OC_DIR] |-> !pad_oe_o);
  assert_no_event_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_rd_o[2:1] == 2'b00) |-> !event_o);
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NUM_PINS  = 13,
  parameter int GRP0_PINS = 7,
  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS,
  localparam int GW = (GRP0_PINS > GRP1_PINS) ? GRP0_PINS : GRP1_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [1:0]          sts_we_i,
  input  logic [1:0]          msk_we_i,
  input  logic [GW-1:0]       wdata_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] status_q, mask_q, clr;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    localparam int GRP = (i < GRP0_PINS) ? 0 : 1;
    localparam int POS = (i < GRP0_PINS) ? i : i - GRP0_PINS;
    assign clr[i] = sts_we_i[GRP] & wdata_i[POS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           mask_q[i] <= 1'b0;
      else if (msk_we_i[GRP]) mask_q[i] <= wdata_i[POS];
    end
  end

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr) | event_i;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr)) == $past(status_q & ~clr)));
  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|event_i) |=> ((status_q & $past(event_i)) == $past(event_i)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS  = 13,
  parameter int GRP0_PINS = 7,
  parameter int ADDR_W    = 6,
  parameter int OC_BASE   = 0,
  parameter int STS_BASE  = 32,
  parameter int MSK_BASE  = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  output logic [7:0]            rd_data_o,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pull_en_o,
  output logic [2*NUM_PINS-1:0] pull_sel_o,
  output logic                  irq_o
);
  localparam int IC_BASE   = OC_BASE + NUM_PINS;
  localparam int GRP1_PINS = NUM_PINS - GRP0_PINS;
  localparam int GW = (GRP0_PINS > GRP1_PINS) ? GRP0_PINS : GRP1_PINS;

  logic [OC_BITS-1:0]  oc_q [NUM_PINS];
  logic [2:0]          ic_rd [NUM_PINS];
  logic [NUM_PINS-1:0] events, status, mask;
  logic [1:0]          sts_we, msk_we;
  logic [7:0]          rd_d, rd_q;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_slice u_pin (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pad_in_i   (pad_in_i[i]),
      .oc_we_i    (wr_en_i && addr_i == ADDR_W'(OC_BASE + i)),
      .oc_wdata_i (wdata_i[OC_BITS-1:0]),
      .ic_we_i    (wr_en_i && addr_i == ADDR_W'(IC_BASE + i)),
      .ic_wdata_i (wdata_i[2:1]),
      .oc_q_o     (oc_q[i]),
      .ic_rd_o    (ic_rd[i]),
      .event_o    (events[i]),
      .pad_out_o  (pad_out_o[i]),
      .pad_oe_o   (pad_oe_o[i]),
      .pull_en_o  (pull_en_o[i]),
      .pull_sel_o (pull_sel_o[2*i+1:2*i])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp_we
    assign sts_we[g] = wr_en_i && addr_i == ADDR_W'(STS_BASE + g);
    assign msk_we[g] = wr_en_i && addr_i == ADDR_W'(MSK_BASE + g);
  end

  gpio_irq_bank #(.NUM_PINS(NUM_PINS), .GRP0_PINS(GRP0_PINS)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (events),
    .sts_we_i (sts_we),
    .msk_we_i (msk_we),
    .wdata_i  (wdata_i[GW-1:0]),
    .status_o (status),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (addr_i == ADDR_W'(OC_BASE + i)) rd_d = 8'(oc_q[i]);
      if (addr_i == ADDR_W'(IC_BASE + i)) rd_d = 8'(ic_rd[i]);
    end
    if (addr_i == ADDR_W'(STS_BASE))     rd_d = 8'(status[GRP0_PINS-1:0]);
    if (addr_i == ADDR_W'(STS_BASE + 1)) rd_d = 8'(status[NUM_PINS-1:GRP0_PINS]);
    if (addr_i == ADDR_W'(MSK_BASE))     rd_d = 8'(mask[GRP0_PINS-1:0]);
    if (addr_i == ADDR_W'(MSK_BASE + 1)) rd_d = 8'(mask[NUM_PINS-1:GRP0_PINS]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  assert_grp1_upper_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(STS_BASE + 1)) |=> (rd_data_o[7:GRP1_PINS] == '0));
  assert_rd_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

// File: tb/tb_gpio_edge_ctrl.sv
module tb_gpio_edge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]   rd_data;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out, pad_oe, pull_en;
  logic [2*N-1:0] pull_sel;
  logic         irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pull_en_o(pull_en), .pull_sel_o(pull_sel), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  function automatic logic [5:0] sts_addr(input int p);
    return (p < 7) ? 6'h20 : 6'h21;
  endfunction
  function automatic int sts_bit(input int p);
    return (p < 7) ? p : p - 7;
  endfunction

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(6'h20, 8'hFF); wr(6'h21, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R10 irq after reset", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 64; a += 3) begin
      rd(6'(a), d); chk("R10 reset read", d, 8'h00);
    end
    rd(6'h28, d); chk("R10 mask0 reset", d, 8'h00);
    rd(6'h29, d); chk("R10 mask1 reset", d, 8'h00);
  endtask

  task automatic t_outctrl();
    logic [7:0] d;
    int pins [3] = '{0, 6, 12};
    logic [7:0] pats [3] = '{8'h2B, 8'h15, 8'h3E};
    for (int k = 0; k < 3; k++) begin
      wr(6'(pins[k]), pats[k]);
      rd(6'(pins[k]), d); chk("R1 oc readback", d, pats[k]);
      chk("R2 pad_out", {7'd0, pad_out[pins[k]]}, {7'd0, pats[k][0]});
      chk("R2 pull_en", {7'd0, pull_en[pins[k]]}, {7'd0, pats[k][3]});
      chk("R2 pull_sel", {6'd0, pull_sel[2*pins[k] +: 2]}, {6'd0, pats[k][2:1]});
    end
  endtask

  task automatic t_oe();
    // dir, drv, lvl -> expected oe
    wr(6'd4, 8'h00); chk("R3 input lvl0", {7'd0, pad_oe[4]}, 8'h00);
    wr(6'd4, 8'h01); chk("R3 input lvl1", {7'd0, pad_oe[4]}, 8'h00);
    wr(6'd4, 8'h30); chk("R3 pushpull lvl0", {7'd0, pad_oe[4]}, 8'h01);
    wr(6'd4, 8'h31); chk("R3 pushpull lvl1", {7'd0, pad_oe[4]}, 8'h01);
    wr(6'd4, 8'h20); chk("R3 opendrain lvl0", {7'd0, pad_oe[4]}, 8'h01);
    wr(6'd4, 8'h21); chk("R3 opendrain lvl1", {7'd0, pad_oe[4]}, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(6'd13 + 6'd5, 8'h04);
    @(negedge clk); pad_in[5] = 1'b1; settle();
    rd(6'd18, d); chk("R4 level high + sel", d, 8'h05);
    @(negedge clk); pad_in[5] = 1'b0; settle();
    rd(6'd18, d); chk("R4 level low", d, 8'h04);
    wr(6'd18, 8'h00); clear_all();
  endtask

  task automatic t_edges();
    logic [7:0] d;
    int pins [3] = '{6, 7, 12};
    for (int k = 0; k < 3; k++) begin
      for (int m = 0; m < 4; m++) begin
        int p = pins[k];
        logic [7:0] b;
        b = 8'(1) << sts_bit(p);
        wr(6'(13 + p), 8'(m << 1));
        clear_all();
        @(negedge clk); pad_in[p] = 1'b1; settle();
        rd(sts_addr(p), d); chk($sformatf("R5 R6 rise pin%0d mode%0d", p, m), d, (m[1] ? b : 8'h00));
        clear_all();
        @(negedge clk); pad_in[p] = 1'b0; settle();
        rd(sts_addr(p), d); chk($sformatf("R5 R6 fall pin%0d mode%0d", p, m), d, (m[0] ? b : 8'h00));
        clear_all();
      end
      wr(6'(13 + pins[k]), 8'h00);
    end
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(6'd13 + 6'd1, 8'h04); wr(6'd13 + 6'd3, 8'h04);
    @(negedge clk); pad_in[1] = 1'b1; pad_in[3] = 1'b1; settle();
    rd(6'h20, d); chk("R7 both set", d, 8'h0A);
    wr(6'h20, 8'h00); rd(6'h20, d); chk("R7 write zero no effect", d, 8'h0A);
    wr(6'h20, 8'h02); rd(6'h20, d); chk("R7 clear one bit", d, 8'h08);
    wr(6'h21, 8'hFF); rd(6'h20, d); chk("R7 other group clear no effect", d, 8'h08);
    wr(6'h20, 8'h08); rd(6'h20, d); chk("R7 clear last", d, 8'h00);
    @(negedge clk); pad_in[1] = 1'b0; pad_in[3] = 1'b0; settle();
    wr(6'd14, 8'h00); wr(6'd16, 8'h00);
  endtask

  task automatic t_race();
    logic [7:0] d;
    wr(6'd13 + 6'd9, 8'h06);
    @(negedge clk); pad_in[9] = 1'b1; settle();
    rd(6'h21, d); chk("R8 pre-set", d, 8'h04);
    @(negedge clk); pad_in[9] = 1'b0;
    @(negedge clk);
    @(negedge clk); addr = 6'h21; wdata = 8'h04; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    rd(6'h21, d); chk("R8 edge beats clear", d, 8'h04);
    wr(6'h21, 8'h04); rd(6'h21, d); chk("R8 plain clear", d, 8'h00);
    wr(6'd22, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(6'd13 + 6'd2, 8'h04); wr(6'd13 + 6'd10, 8'h04);
    @(negedge clk); pad_in[2] = 1'b1; settle();
    chk("R9 irq on pin2", {7'd0, irq}, 8'h01);
    wr(6'h28, 8'h04); chk("R9 masked pin2", {7'd0, irq}, 8'h00);
    rd(6'h28, d); chk("R9 mask0 readback", d, 8'h04);
    rd(6'h20, d); chk("R9 status kept under mask", d, 8'h04);
    @(negedge clk); pad_in[10] = 1'b1; settle();
    chk("R9 irq on pin10", {7'd0, irq}, 8'h01);
    wr(6'h29, 8'h08); chk("R9 R6 masked pin10", {7'd0, irq}, 8'h00);
    wr(6'h28, 8'h00); chk("R9 unmask pin2", {7'd0, irq}, 8'h01);
    clear_all(); chk("R9 irq after clear", {7'd0, irq}, 8'h00);
    wr(6'h29, 8'h00);
    @(negedge clk); pad_in[2] = 1'b0; pad_in[10] = 1'b0; settle();
    wr(6'd15, 8'h00); wr(6'd23, 8'h00); clear_all();
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(6'h29, 8'hFF); rd(6'h29, d); chk("R11 mask1 width", d, 8'h3F);
    wr(6'h28, 8'hFF); rd(6'h28, d); chk("R11 mask0 width", d, 8'h7F);
    wr(6'h28, 8'h00); wr(6'h29, 8'h00);
    wr(6'd8, 8'hC0); rd(6'd8, d); chk("R11 oc upper bits", d, 8'h00);
    wr(6'd20, 8'hF9); rd(6'd20, d); chk("R11 ic upper bits", d, 8'h00);
    wr(6'd20, 8'hFF); rd(6'd20, d); chk("R11 ic readable bits", d, 8'h06);
    wr(6'd20, 8'h00);
    wr(6'h30, 8'hA5); rd(6'h30, d); chk("R11 unmapped", d, 8'h00);
  endtask

  task automatic t_rdlat();
    logic [7:0] d;
    wr(6'd11, 8'h2A);
    rd(6'd11, d); chk("R12 read", d, 8'h2A);
    @(negedge clk); addr = 6'd0;
    @(negedge clk); chk("R12 hold without strobe", rd_data, 8'h2A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_outctrl();
    t_oe();
    t_level();
    t_edges();
    t_w1c();
    t_race();
    t_mask();
    t_unused();
    t_rdlat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule